// File: doc/BRIEF.md
# Command Queue Trigger Status Controller

This block follows the run state of a single command queue that feeds conversion commands to a converter back-end. It reports one of three states: IDLE, WAITING FOR TRIGGER or TRIGGERED. The state moves according to four things: the selected operating mode, a trigger input, and the end-of-queue and pause marks carried by each command as its transfer finishes. The trigger input acts as an edge source in edge modes and as a gate in level modes. A separate flag remembers that a command marked end-of-queue has finished transferring. When its enable is set, that flag raises an interrupt request.

The surrounding FIFO supplies three things: a busy level while a command is being moved, a one-cycle completion or abort pulse when the move ends, and the two marks of the finished command alongside that pulse. Software chooses the mode. Writing a new enabled mode value arms the queue. Choosing the disabled value stops it, but only once any command already in flight has ended.

Top module: `cq_trig_status`

## Requirements
- R1: The status encodes IDLE as 2'b00, WAITING FOR TRIGGER as 2'b10 and TRIGGERED as 2'b11, and 2'b01 never appears. Reset gives IDLE with the end-of-queue flag low.
- R2: The mode codes are: 0 disabled, 1 single-scan edge, 2 single-scan level, 3 continuous-scan edge, 4 continuous-scan level; codes 5 to 7 act as disabled. In IDLE, a mode input that changes to an enabled code moves the status to WAITING FOR TRIGGER on the next edge. An unchanged mode leaves IDLE in place, whatever the trigger does.
- R3: In WAITING FOR TRIGGER, edge modes go to TRIGGERED only on a low-to-high change of the trigger. Level modes go to TRIGGERED while the gate (trigger input) is high.
- R4: In single-scan modes, a completion pulse with the end-of-queue mark moves TRIGGERED to IDLE.
- R5: In edge modes, a completion with the pause mark set and the end-of-queue mark clear moves TRIGGERED to WAITING FOR TRIGGER. In level modes the pause mark has no effect.
- R6: In continuous-scan edge mode, a completion with the end-of-queue mark moves TRIGGERED to WAITING FOR TRIGGER.
- R7: In level modes, TRIGGERED leaves when the gate is low at a completion pulse, or low while no transfer is busy. The target is IDLE for single-scan and WAITING FOR TRIGGER for continuous-scan. A low gate during a busy transfer does nothing until the transfer ends.
- R8: With the disabled mode, TRIGGERED goes to IDLE at once if no transfer is busy. Otherwise it waits for the completion or abort pulse. WAITING FOR TRIGGER goes to IDLE at once.
- R9: TRIGGERED holds when none of the conditions in R4 to R8 occurs.
- R10: The end-of-queue flag sets on any completion pulse with the end-of-queue mark. It clears on a clear pulse. When both arrive in the same cycle, the flag stays set.
- R11: The interrupt request is high exactly while the flag and its enable are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating mode code (see R2) |
| trig_i | input | 1 | Trigger edge source or gate level |
| busy_i | input | 1 | A command transfer is in progress |
| done_i | input | 1 | One-cycle pulse: the current transfer completed |
| abort_i | input | 1 | One-cycle pulse: the current transfer was abandoned |
| cmd_eoq_i | input | 1 | End-of-queue mark of the finishing command |
| cmd_pause_i | input | 1 | Pause mark of the finishing command |
| eoq_clr_i | input | 1 | Write-one-to-clear pulse for the end-of-queue flag |
| eoq_ie_i | input | 1 | End-of-queue interrupt enable |
| status_o | output | 2 | Queue status |
| eoq_flag_o | output | 1 | Sticky end-of-queue flag |
| irq_o | output | 1 | End-of-queue interrupt request |

## Verification
The status and the flag are registered, so every stimulus applied before a rising edge shows on those outputs just after that same edge, one cycle later. The interrupt request is a combination of the registered flag and the live enable, so it follows the enable in the same cycle. The driver applies each step's inputs on the falling edge and pushes the result expected after the next rising edge. The monitor compares a moment after that rising edge, which keeps every check in the cycle its result becomes due.

// File: rtl/cq_trig_pkg.sv
package cq_trig_pkg;

    localparam int MODE_W = 3;
    localparam int STAT_W = 2;

    typedef enum logic [STAT_W-1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b10,
        ST_TRIG = 2'b11
    } q_status_e;

    localparam logic [MODE_W-1:0] MODE_OFF     = 3'd0;
    localparam logic [MODE_W-1:0] MODE_SGL_EDG = 3'd1;
    localparam logic [MODE_W-1:0] MODE_SGL_LVL = 3'd2;
    localparam logic [MODE_W-1:0] MODE_CNT_EDG = 3'd3;
    localparam logic [MODE_W-1:0] MODE_CNT_LVL = 3'd4;

    typedef struct packed {
        logic enabled;
        logic cont;
        logic level;
    } mode_info_t;

endpackage

// File: rtl/cq_mode_dec.sv
module cq_mode_dec
    import cq_trig_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output mode_info_t        info_o
);
    always_comb begin
        info_o = '0;
        unique case (mode_i)
            MODE_SGL_EDG: info_o = '{enabled: 1'b1, cont: 1'b0, level: 1'b0};
            MODE_SGL_LVL: info_o = '{enabled: 1'b1, cont: 1'b0, level: 1'b1};
            MODE_CNT_EDG: info_o = '{enabled: 1'b1, cont: 1'b1, level: 1'b0};
            MODE_CNT_LVL: info_o = '{enabled: 1'b1, cont: 1'b1, level: 1'b1};
            default:      info_o = '0;
        endcase
    end
endmodule

// File: rtl/cq_trig_detect.sv
module cq_trig_detect
    import cq_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              enabled_i,
    input  logic              trig_i,
    output logic              rise_o,
    output logic              arm_o
);
    typedef struct packed {
        logic              trig_prev;
        logic [MODE_W-1:0] mode_prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d           = det_q;
        det_d.trig_prev = trig_i;
        det_d.mode_prev = mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '{trig_prev: 1'b0, mode_prev: MODE_OFF};
        else        det_q <= det_d;
    end

    assign rise_o = trig_i & ~det_q.trig_prev;
    assign arm_o  = enabled_i && (mode_i != det_q.mode_prev);
endmodule

// File: rtl/cq_status_fsm.sv
module cq_status_fsm
    import cq_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mode_info_t info_i,
    input  logic       arm_i,
    input  logic       rise_i,
    input  logic       gate_i,
    input  logic       busy_i,
    input  logic       done_i,
    input  logic       abort_i,
    input  logic       eoq_i,
    input  logic       pause_i,
    output q_status_e  status_o
);
    typedef struct packed {
        q_status_e status;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.status)
            ST_IDLE: begin
                if (arm_i) fsm_d.status = ST_WAIT;
            end
            ST_WAIT: begin
                if (!info_i.enabled)
                    fsm_d.status = ST_IDLE;
                else if (info_i.level ? gate_i : rise_i)
                    fsm_d.status = ST_TRIG;
            end
            ST_TRIG: begin
                if (!info_i.enabled) begin
                    if (!busy_i || done_i || abort_i) fsm_d.status = ST_IDLE;
                end else if (done_i) begin
                    if (!info_i.cont && eoq_i)
                        fsm_d.status = ST_IDLE;
                    else if (info_i.level && !gate_i)
                        fsm_d.status = info_i.cont ? ST_WAIT : ST_IDLE;
                    else if (!info_i.level && pause_i && !eoq_i)
                        fsm_d.status = ST_WAIT;
                    else if (!info_i.level && info_i.cont && eoq_i)
                        fsm_d.status = ST_WAIT;
                end else if (info_i.level && !gate_i && !busy_i) begin
                    fsm_d.status = info_i.cont ? ST_WAIT : ST_IDLE;
                end
            end
            default: fsm_d.status = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{status: ST_IDLE};
        else        fsm_q <= fsm_d;
    end

    assign status_o = fsm_q.status;

    // R1
    no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.status != 2'b01);

    // R2
    no_idle_to_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.status == ST_IDLE |=> fsm_q.status != ST_TRIG);

    // R8
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!info_i.enabled && !busy_i) |=> fsm_q.status == ST_IDLE);

    // R4
    single_eoq_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.status == ST_TRIG && info_i.enabled && !info_i.cont && done_i && eoq_i)
        |=> fsm_q.status == ST_IDLE);
endmodule

// File: rtl/cq_eoq_flag.sv
module cq_eoq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie_i,
    output logic flag_o,
    output logic irq_o
);
    typedef struct packed {
        logic flag;
    } flg_t;

    flg_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (set_i)      flg_d.flag = 1'b1;
        else if (clr_i) flg_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '{flag: 1'b0};
        else        flg_q <= flg_d;
    end

    assign flag_o = flg_q.flag;
    assign irq_o  = flg_q.flag & ie_i;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flg_q.flag);

    // R10
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flg_q.flag);
endmodule

// File: rtl/cq_trig_status.sv
module cq_trig_status
    import cq_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       trig_i,
    input  logic       busy_i,
    input  logic       done_i,
    input  logic       abort_i,
    input  logic       cmd_eoq_i,
    input  logic       cmd_pause_i,
    input  logic       eoq_clr_i,
    input  logic       eoq_ie_i,
    output logic [1:0] status_o,
    output logic       eoq_flag_o,
    output logic       irq_o
);
    mode_info_t info;
    logic       rise, arm;
    q_status_e  status;

    cq_mode_dec u_dec (
        .mode_i (mode_i),
        .info_o (info)
    );

    cq_trig_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .enabled_i (info.enabled),
        .trig_i    (trig_i),
        .rise_o    (rise),
        .arm_o     (arm)
    );

    cq_status_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .info_i   (info),
        .arm_i    (arm),
        .rise_i   (rise),
        .gate_i   (trig_i),
        .busy_i   (busy_i),
        .done_i   (done_i),
        .abort_i  (abort_i),
        .eoq_i    (cmd_eoq_i),
        .pause_i  (cmd_pause_i),
        .status_o (status)
    );

    cq_eoq_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (done_i & cmd_eoq_i),
        .clr_i  (eoq_clr_i),
        .ie_i   (eoq_ie_i),
        .flag_o (eoq_flag_o),
        .irq_o  (irq_o)
    );

    assign status_o = status;
endmodule

// File: tb/cq_trig_status_test.sv
module cq_trig_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = '0;
    logic       trig_i = 0, busy_i = 0, done_i = 0, abort_i = 0;
    logic       cmd_eoq_i = 0, cmd_pause_i = 0, eoq_clr_i = 0, eoq_ie_i = 0;
    logic [1:0] status_o;
    logic       eoq_flag_o, irq_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    typedef struct {
        logic [1:0] st;
        logic       flag;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    cq_trig_status uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .trig_i(trig_i),
        .busy_i(busy_i), .done_i(done_i), .abort_i(abort_i),
        .cmd_eoq_i(cmd_eoq_i), .cmd_pause_i(cmd_pause_i),
        .eoq_clr_i(eoq_clr_i), .eoq_ie_i(eoq_ie_i),
        .status_o(status_o), .eoq_flag_o(eoq_flag_o), .irq_o(irq_o)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (status_o !== e.st || eoq_flag_o !== e.flag || irq_o !== e.irq) begin
            fails++;
            $display("FAIL %s: got st=%b flag=%b irq=%b, expected st=%b flag=%b irq=%b",
                     e.tag, status_o, eoq_flag_o, irq_o, e.st, e.flag, e.irq);
        end
    endtask

    // driver: apply on falling edge, result due after the next rising edge
    task automatic cyc(input logic [2:0] m, input logic t, input logic b,
                       input logic d, input logic a, input logic eq,
                       input logic p, input logic c, input logic ie,
                       input logic [1:0] st, input logic fl, input logic ir,
                       input string tag);
        exp_t e;
        @(negedge clk);
        mode_i = m; trig_i = t; busy_i = b; done_i = d; abort_i = a;
        cmd_eoq_i = eq; cmd_pause_i = p; eoq_clr_i = c; eoq_ie_i = ie;
        e.st = st; e.flag = fl; e.irq = ir; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) compare(sb.pop_front());
    end

    localparam logic [1:0] I = 2'b00, W = 2'b10, T = 2'b11;

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        r.st = I; r.flag = 1'b0; r.irq = 1'b0; r.tag = "R1 reset state";
        compare(r);
        rst_n = 1'b1;
        //   mode t  b  d  a  eq p  c  ie  st fl ir
        cyc(3'd1,0,0,0,0,0,0,0,0, W,0,0, "R2 arm single edge");
        cyc(3'd1,0,0,0,0,0,0,0,0, W,0,0, "R3 no edge waits");
        cyc(3'd1,1,0,0,0,0,0,0,0, T,0,0, "R3 rising edge triggers");
        cyc(3'd1,1,1,0,0,0,0,0,0, T,0,0, "R9 hold while busy");
        cyc(3'd1,1,1,1,0,0,1,0,0, W,0,0, "R5 pause in edge mode");
        cyc(3'd1,0,0,0,0,0,0,0,0, W,0,0, "R3 low trigger waits");
        cyc(3'd1,1,0,0,0,0,0,0,0, T,0,0, "R3 second edge");
        cyc(3'd1,1,1,1,0,1,0,0,1, I,1,1, "R4 R10 R11 single eoq stops");
        cyc(3'd1,1,0,0,0,0,0,0,0, I,1,0, "R2 R11 unchanged mode stays idle");
        cyc(3'd1,0,0,0,0,0,0,1,1, I,0,0, "R10 clear flag");
        cyc(3'd2,0,0,0,0,0,0,0,0, W,0,0, "R2 arm single level");
        cyc(3'd2,1,0,0,0,0,0,0,0, T,0,0, "R3 gate open triggers");
        cyc(3'd2,0,1,0,0,0,0,0,0, T,0,0, "R7 gate low while busy ignored");
        cyc(3'd2,0,1,1,0,0,1,0,0, I,0,0, "R7 gate low at completion single");
        cyc(3'd4,1,0,0,0,0,0,0,0, W,0,0, "R2 arm continuous level");
        cyc(3'd4,1,0,0,0,0,0,0,0, T,0,0, "R3 level gate open");
        cyc(3'd4,1,1,1,0,0,1,0,0, T,0,0, "R5 pause ignored in level");
        cyc(3'd4,0,0,0,0,0,0,0,0, W,0,0, "R7 gate low idle continuous");
        cyc(3'd4,1,0,0,0,0,0,0,0, T,0,0, "R3 gate reopens");
        cyc(3'd4,1,1,1,0,1,0,1,1, T,1,1, "R10 set wins over clear, R9 hold");
        cyc(3'd3,1,0,0,0,0,0,0,1, T,1,1, "R9 hold after mode switch");
        cyc(3'd3,1,1,1,0,1,0,0,0, W,1,0, "R6 continuous edge eoq rearms");
        cyc(3'd3,1,0,0,0,0,0,0,0, W,1,0, "R3 high level is no edge");
        cyc(3'd3,0,0,0,0,0,0,0,0, W,1,0, "R3 trigger low");
        cyc(3'd3,1,0,0,0,0,0,0,0, T,1,0, "R3 continuous edge triggers");
        cyc(3'd0,0,1,0,0,0,0,0,0, T,1,0, "R8 disable waits for transfer");
        cyc(3'd0,0,1,0,0,0,0,0,0, T,1,0, "R8 still waiting");
        cyc(3'd0,0,1,0,1,0,0,0,0, I,1,0, "R8 abort ends disabled queue");
        cyc(3'd3,0,0,0,0,0,0,0,0, W,1,0, "R2 rearm continuous edge");
        cyc(3'd3,1,0,0,0,0,0,0,0, T,1,0, "R3 edge");
        cyc(3'd0,0,0,0,0,0,0,0,0, I,1,0, "R8 disable not busy");
        cyc(3'd1,0,0,0,0,0,0,0,0, W,1,0, "R2 arm again");
        cyc(3'd7,0,0,0,0,0,0,0,0, I,1,0, "R2 R8 code 7 disables wait");
        cyc(3'd0,0,0,0,0,0,0,1,1, I,0,0, "R10 R11 clear");
        @(negedge clk);
        @(negedge clk);
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule